// File: doc/BRIEF.md
# Stereo Near-Full-Scale Overload Flag

This block sits on the recording path after decimation and watches each stereo sample pair as it is strobed in. When the magnitude of the left or the right sample climbs above a fixed threshold just below full digital scale (about 1.16 dB under it), a single-bit overload flag goes high. The flag then stays high for a fixed number of sample periods after the most recent offending sample, so a short burst of clipping gives a steady indication that a level meter or a record-level control loop can read.

The hold timer counts sample strobes, not system clocks, so the hold time follows the audio rate whatever the ratio between the system clock and the sample rate. With the default 512-sample hold and a 44.1 kHz rate the flag lasts about 11.6 ms after the last violation. Any new violation during the hold reloads the timer to its full value.

Top module: `ovl_flag_det`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag and the hold counter are cleared; after that edge `ovl_flag` reads 0.
- R2: Sample magnitude is the absolute value of the two's-complement sample; the most negative code saturates to the largest positive magnitude and therefore always counts as a violation.
- R3: A sample violates when its magnitude is strictly greater than LIMIT = round(0.8748 × (2^(SAMPLE_W−1) − 1)); a magnitude equal to LIMIT does not violate (LIMIT is 111 for 8-bit samples and 458646 for 20-bit samples).
- R4: A violation on either channel alone is enough to set the flag.
- R5: A strobe (`smp_stb` high at a rising edge) carrying a violation makes `ovl_flag` high from that same edge onward.
- R6: After the last violating strobe the flag stays high for exactly HOLD_SAMPLES further non-violating strobes and falls at the edge of the HOLD_SAMPLES-th one.
- R7: A violating strobe during the hold restarts the hold from its full value of HOLD_SAMPLES.
- R8: Samples presented while `smp_stb` is low have no effect: the flag and the remaining hold time do not change.
- R9: The default configuration is 20-bit samples and a 512-sample hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a valid stereo sample pair |
| left_smp | input | SAMPLE_W | Left sample, signed two's complement |
| right_smp | input | SAMPLE_W | Right sample, signed two's complement |
| ovl_flag | output | 1 | Overload flag, held after the last violation |

## Verification
A small 8-bit, 6-sample-hold instance is swept over every sample code on the left channel with the right at zero and then the reverse, which separates the threshold boundary (111 against 112 and −111 against −112), the saturating most negative code and the independence of the two channels. Each violating strobe is followed by a run of clean strobes checked one by one, which pins the exact hold length rather than only "stays high for a while". A retrigger pattern places a second violation mid-hold to tell a reload from a counter that keeps running, and violating samples without a strobe show whether unstrobed data leaks into the flag or the timer. A default-parameter instance checks the 20-bit threshold edge and the full 512-sample hold.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  // Ratio of the threshold to full scale, in units of 1/10000.
  localparam longint THRESH_NUM = 8748;
  localparam longint THRESH_DEN = 10000;

  // Largest positive code for a signed sample of width w.
  function automatic longint full_scale(input int w);
    return (longint'(1) << (w - 1)) - 1;
  endfunction

  // Rounded magnitude threshold for a signed sample of width w.
  function automatic longint thresh_for(input int w);
    return (full_scale(w) * THRESH_NUM + THRESH_DEN / 2) / THRESH_DEN;
  endfunction

endpackage

// File: rtl/ovl_chan_det.sv
module ovl_chan_det #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic [SAMPLE_W-2:0] mag_o,
  output logic                viol_o
);

  localparam int MAG_W = SAMPLE_W - 1;
  localparam logic [MAG_W-1:0] LIMIT = MAG_W'(ovl_pkg::thresh_for(SAMPLE_W));
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  // Saturating absolute value of a two's-complement code.
  function automatic logic [MAG_W-1:0] sat_abs(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] neg;
    neg = ~s + SAMPLE_W'(1);
    if (!s[SAMPLE_W-1])
      return s[MAG_W-1:0];
    else if (neg[SAMPLE_W-1])
      return {MAG_W{1'b1}};
    else
      return neg[MAG_W-1:0];
  endfunction

  assign mag_o  = sat_abs(smp_i);
  assign viol_o = (mag_o > LIMIT);

  // R2
  min_code_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_i == MOST_NEG) |-> viol_o);

  // R3
  thresh_band_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o == (($signed(smp_i) > $signed({1'b0, LIMIT})) ||
               ($signed(smp_i) < -$signed({1'b0, LIMIT}))));

endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer #(
  parameter int HOLD_SAMPLES = 512
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 stb_i,
  input  logic                                 hit_i,
  output logic [$clog2(HOLD_SAMPLES+1)-1:0]    cnt_o,
  output logic                                 flag_o
);

  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_SAMPLES);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             flag_q;
  logic             reload, tick_down;

  assign reload    = stb_i && hit_i;
  assign tick_down = stb_i && !hit_i && (cnt_q != '0);

  always_comb begin
    cnt_n = cnt_q;
    if (reload)
      cnt_n = HOLD_C;
    else if (tick_down)
      cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= (cnt_n != '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!flag_o && (cnt_o == '0)));

  // R5
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && hit_i) |=> flag_o);

  // R7
  reload_full_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && hit_i) |=> (cnt_o == HOLD_C));

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !hit_i && (cnt_o != '0)) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

  // R6
  flag_tracks_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    flag_o == (cnt_o != '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> ($stable(cnt_o) && $stable(flag_o)));

endmodule

// File: rtl/ovl_flag_det.sv
module ovl_flag_det #(
  parameter int SAMPLE_W     = 20,
  parameter int HOLD_SAMPLES = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                ovl_flag
);

  localparam int NCH   = 2;
  localparam int MAG_W = SAMPLE_W - 1;
  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);

  logic [NCH-1:0][SAMPLE_W-1:0] smp;
  logic [NCH-1:0][MAG_W-1:0]    mag;
  logic [NCH-1:0]               viol;
  logic                         any_viol;
  logic [CNT_W-1:0]             hold_cnt;

  assign smp[0] = left_smp;
  assign smp[1] = right_smp;

  for (genvar ch = 0; ch < NCH; ch++) begin : chan_g
    ovl_chan_det #(.SAMPLE_W(SAMPLE_W)) det_i (
      .clk    (clk),
      .rst    (rst),
      .smp_i  (smp[ch]),
      .mag_o  (mag[ch]),
      .viol_o (viol[ch])
    );
  end

  assign any_viol = |viol;

  ovl_hold_timer #(.HOLD_SAMPLES(HOLD_SAMPLES)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .stb_i  (smp_stb),
    .hit_i  (any_viol),
    .cnt_o  (hold_cnt),
    .flag_o (ovl_flag)
  );

  // R4
  left_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && viol[0]) |=> ovl_flag);

  // R4
  right_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && viol[1]) |=> ovl_flag);

endmodule

// File: tb/ovl_flag_det_tb_top.sv
module ovl_flag_det_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SW   = 8;
  localparam int HOLD = 6;
  localparam int DSW  = 20;
  localparam int DHOLD = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic [SW-1:0] lsmp = '0, rsmp = '0;
  logic flag;

  logic dstb = 1'b0;
  logic [DSW-1:0] dl = '0, dr = '0;
  logic dflag;

  int n_cmp = 0;
  int n_bad = 0;
  int model_cnt = 0;
  int lim_s, lim_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_flag_det #(.SAMPLE_W(SW), .HOLD_SAMPLES(HOLD)) dut_i (
    .clk(clk), .rst(rst), .smp_stb(stb),
    .left_smp(lsmp), .right_smp(rsmp), .ovl_flag(flag));

  ovl_flag_det dflt_i (
    .clk(clk), .rst(rst), .smp_stb(dstb),
    .left_smp(dl), .right_smp(dr), .ovl_flag(dflag));

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int absval(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Strobe one pair into the small instance and check against the model.
  task automatic strobe(input int l, input int r, input string req);
    @(negedge clk);
    lsmp = SW'(l); rsmp = SW'(r); stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    if (absval(l) > lim_s || absval(r) > lim_s) model_cnt = HOLD;
    else if (model_cnt > 0) model_cnt--;
    check(req, flag, model_cnt != 0);
  endtask

  task automatic dstrobe(input int l, input int r);
    @(negedge clk);
    dl = DSW'(l); dr = DSW'(r); dstb = 1'b1;
    @(negedge clk);
    dstb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    lim_s = int'($floor(0.8748 * real'((1 << (SW-1)) - 1) + 0.5));
    lim_d = int'($floor(0.8748 * real'((1 << (DSW-1)) - 1) + 0.5));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset small", flag, 1'b0);
    check("R1 reset default", dflag, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", flag, 1'b0);

    // R3 boundary, R5 set on the strobe edge
    strobe(lim_s, 0, "R3 equal limit");
    strobe(-lim_s, 0, "R3 equal negative limit");
    strobe(lim_s + 1, 0, "R3 R5 just above");
    for (int k = 0; k < HOLD; k++) strobe(0, 0, "R6 hold");

    // R2: most negative code
    strobe(-(1 << (SW-1)), 0, "R2 most negative");
    for (int k = 0; k < HOLD; k++) strobe(0, 0, "R6 hold after R2");

    // Sweep left then right over every code: R3 R4 R6
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = -(1 << (SW-1)); v < (1 << (SW-1)); v++) begin
        if (ch == 0) strobe(v, 0, "R3 R4 sweep left");
        else         strobe(0, v, "R3 R4 sweep right");
        for (int k = 0; k < HOLD; k++) strobe(v / 4, -v / 4, "R6 sweep hold");
      end
    end

    // R7: retrigger mid-hold
    strobe(0, -120, "R7 first hit");
    for (int k = 0; k < 3; k++) strobe(5, 5, "R7 partial hold");
    strobe(127, 0, "R7 second hit");
    for (int k = 0; k < HOLD; k++) strobe(0, 0, "R7 full hold restarted");

    // R8: unstrobed violating data is ignored (flag low case)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lsmp = SW'(-128); rsmp = SW'(127); stb = 1'b0;
      @(negedge clk);
      check("R8 idle while clear", flag, 1'b0);
    end
    // R8: during hold, unstrobed data neither reloads nor counts
    strobe(120, 0, "R8 arm");
    strobe(0, 0, "R8 one clean");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      lsmp = SW'(-128); stb = 1'b0;
      @(negedge clk);
      check("R8 idle while held", flag, 1'b1);
    end
    for (int k = 0; k < HOLD - 1; k++) strobe(0, 0, "R8 remaining hold unchanged");

    // R9: default configuration threshold and 512-sample hold
    dstrobe(lim_d, -lim_d);
    check("R9 R3 default at limit", dflag, 1'b0);
    dstrobe(0, -(lim_d + 1));
    check("R9 R4 default above limit", dflag, 1'b1);
    for (int k = 1; k < DHOLD; k++) dstrobe(1000, -1000);
    check("R9 R6 default still held", dflag, 1'b1);
    dstrobe(0, 0);
    check("R9 R6 default released at 512", dflag, 1'b0);

    // R1: reset clears a held flag
    strobe(127, 127, "R1 arm");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears held flag", flag, 1'b0);
    rst = 1'b0; model_cnt = 0;
    strobe(0, 0, "R1 counter cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule